// File: doc/BRIEF.md
# Microstepping Phase-Current Translator

This block turns a stream of step pulses into a pair of signed current setpoints for the two windings of a bipolar stepper motor. It keeps a position index on a ring of 32 positions per electrical revolution, spaced 11.25 degrees apart. For each winding it outputs a magnitude code, a polarity bit and the decay mode the current chopper should use. Winding A follows the cosine of the electrical angle and winding B follows the sine. The analog reference scaling, the chopper and the power bridges sit downstream and are not part of this block.

Each rising edge on the step input moves the index by one increment, in the direction set by the direction bit. The two resolution bits are sampled on that same edge and select full, half, quarter or eighth steps. When a winding's new magnitude is lower than its previous one, its decay mode comes from a 2-bit fast-decay selection. Otherwise that winding uses slow decay. An active-low reset or an undervoltage-reset request returns the position to home at 45 degrees and sets both windings to mixed decay.

Top module: `stp_translator`

## Requirements
- R1: After reset the index is home (position 4, 45 degrees). Both magnitudes are 180, both polarity bits are 0 and both decay outputs are 01 (mixed).
- R2: The magnitude at index i is round(255*|cos(i*11.25 deg)|) for winding A and round(255*|sin(i*11.25 deg)|) for winding B. This gives codes 255, 250, 236, 212, 180, 142, 98, 50 and 0. A polarity bit is 1 only when its signed value is strictly negative, so a zero level has polarity 0.
- R3: On a step, the index moves by 8, 4, 2 or 1 for resolution bits {res_b,res_a} = 00, 01, 10, 11 respectively. It moves up when dir_in=1 and down when dir_in=0, and wraps modulo 32.
- R4: Only a low-to-high transition of step_in advances the index. A level held high gives one advance only. The outputs change at the first clock edge that sees step_in high after it was low.
- R5: Changes on res_a and res_b have no effect until the next step edge, where they are sampled.
- R6: While rst_n is low, the outputs stay at the home state and step edges are ignored.
- R7: uv_req high returns the block to the home state at the next clock edge, with both decay outputs at mixed. Step edges are ignored while uv_req is high.
- R8: On a step, a winding whose new magnitude is lower than its previous one takes its decay output from pfd_sel: 00 gives slow (00), 01 gives mixed (01), 10 gives fast (10) and 11 gives mixed (01). A winding whose new magnitude is equal or higher gets slow (00). Decay outputs hold between steps.
- R9: A change of resolution does not realign the index. The index advances from its current value by the new increment, so a full step from index 5 lands on 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset to home |
| step_in | input | 1 | Step strobe, advances on its rising edge |
| dir_in | input | 1 | 1 increases angle, 0 decreases |
| res_a | input | 1 | Resolution select, low bit |
| res_b | input | 1 | Resolution select, high bit |
| pfd_sel | input | 2 | Decay used for falling magnitude: 00 slow, 01 mixed, 10 fast |
| uv_req | input | 1 | Synchronous request to return to home |
| ph1_mag | output | 8 | Winding A magnitude code |
| ph1_neg | output | 1 | Winding A polarity, 1 = negative |
| ph1_decay | output | 2 | Winding A decay mode |
| ph2_mag | output | 8 | Winding B magnitude code |
| ph2_neg | output | 1 | Winding B polarity, 1 = negative |
| ph2_decay | output | 2 | Winding B decay mode |

## Verification
The bench walks a full revolution in eighth steps in both directions, so that every zero crossing and every sign change is visited. A design that reported a negative zero, or a cosine off by one position, would miscompare there. It holds step_in high across several clocks to catch level-sensitive advancing, and it changes the resolution bits between steps to catch a design that uses them before the edge. It also steps from an odd index in full-step mode, which exposes a design that snaps back to a diagonal. Decay checks follow each winding independently through rising, equal and falling magnitudes under every pfd_sel code, including the unused 11 code. Reset and undervoltage requests are applied away from home with step edges during them, which exposes a design that leaks a step or leaves decay at slow.

// File: rtl/stp_pkg.sv
package stp_pkg;
  parameter int IDX_W     = 5;
  localparam int POSITIONS = 1 << IDX_W;
  localparam int QUAD      = POSITIONS / 4;
  parameter int MAG_W     = 8;
  localparam logic [MAG_W-1:0] FULL_MAG = {MAG_W{1'b1}};
  localparam logic [IDX_W-1:0] HOME_IDX = IDX_W'(POSITIONS / 8);

  typedef enum logic [1:0] {
    DEC_SLOW  = 2'b00,
    DEC_MIXED = 2'b01,
    DEC_FAST  = 2'b10
  } decay_t;

  // cos(k * 11.25 deg) scaled to full code, k = 0..8
  function automatic logic [MAG_W-1:0] level_mag(input logic [3:0] k);
    case (k)
      4'd0:    level_mag = 8'd255;
      4'd1:    level_mag = 8'd250;
      4'd2:    level_mag = 8'd236;
      4'd3:    level_mag = 8'd212;
      4'd4:    level_mag = 8'd180;
      4'd5:    level_mag = 8'd142;
      4'd6:    level_mag = 8'd98;
      4'd7:    level_mag = 8'd50;
      default: level_mag = 8'd0;
    endcase
  endfunction

  function automatic logic [3:0] cos_level(input logic [IDX_W-1:0] idx);
    logic [3:0] r;
    r = {1'b0, idx[2:0]};
    cos_level = idx[3] ? (4'd8 - r) : r;
  endfunction

  function automatic logic [MAG_W-1:0] wave_mag(input logic [IDX_W-1:0] idx,
                                                input logic use_sin);
    logic [IDX_W-1:0] shifted;
    shifted = use_sin ? (idx - IDX_W'(QUAD)) : idx;
    wave_mag = level_mag(cos_level(shifted));
  endfunction

  function automatic logic wave_neg(input logic [IDX_W-1:0] idx,
                                    input logic use_sin);
    if (use_sin) wave_neg = (idx > IDX_W'(2 * QUAD));
    else         wave_neg = (idx > IDX_W'(QUAD)) && (idx < IDX_W'(3 * QUAD));
  endfunction

  function automatic logic [IDX_W-1:0] step_inc(input logic ms_lo, input logic ms_hi);
    step_inc = IDX_W'(QUAD) >> {ms_hi, ms_lo};
  endfunction

  function automatic decay_t falling_decay(input logic [1:0] sel);
    case (sel)
      2'b00:   falling_decay = DEC_SLOW;
      2'b10:   falling_decay = DEC_FAST;
      default: falling_decay = DEC_MIXED;
    endcase
  endfunction
endpackage

// File: rtl/stp_edge.sv
module stp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  input  logic clr,
  output logic step_evt
);
  logic step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 1'b1;
    else        step_q <= step_in;
  end

  assign step_evt = step_in & ~step_q & ~clr;

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> !step_evt);
endmodule

// File: rtl/stp_index.sv
module stp_index
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step_evt,
  input  logic             dir_in,
  input  logic             res_a,
  input  logic             res_b,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] idx_nxt
);
  logic [IDX_W-1:0] inc;

  assign inc     = step_inc(res_a, res_b);
  assign idx_nxt = dir_in ? (idx + inc) : (idx - inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx <= HOME_IDX;
    else if (clr)      idx <= HOME_IDX;
    else if (step_evt) idx <= idx_nxt;
  end

  assert_home_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == HOME_IDX));
  assert_step_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !clr) |=> (idx != $past(idx)));
  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !clr) |=> $stable(idx));
endmodule

// File: rtl/stp_phase.sv
module stp_phase
  import stp_pkg::*;
#(
  parameter bit USE_SIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step_evt,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] idx_nxt,
  input  logic [1:0]       pfd_sel,
  output logic [MAG_W-1:0] mag,
  output logic             neg,
  output logic [1:0]       decay
);
  logic [MAG_W-1:0] mag_nxt;
  logic             mag_falls;
  decay_t           decay_q;

  assign mag       = wave_mag(idx, USE_SIN);
  assign neg       = wave_neg(idx, USE_SIN);
  assign mag_nxt   = wave_mag(idx_nxt, USE_SIN);
  assign mag_falls = (mag_nxt < mag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        decay_q <= DEC_MIXED;
    else if (clr)      decay_q <= DEC_MIXED;
    else if (step_evt) decay_q <= mag_falls ? falling_decay(pfd_sel) : DEC_SLOW;
  end

  assign decay = decay_q;

  assert_rise_is_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_evt && !clr) && (mag >= $past(mag))) |-> (decay == DEC_SLOW));
  assert_decay_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !clr) |=> $stable(decay));
  assert_clear_mixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (decay == DEC_MIXED));
  assert_zero_positive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mag == '0) |-> !neg);
endmodule

// File: rtl/stp_translator.sv
module stp_translator
  import stp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_in,
  input  logic       dir_in,
  input  logic       res_a,
  input  logic       res_b,
  input  logic [1:0] pfd_sel,
  input  logic       uv_req,
  output logic [7:0] ph1_mag,
  output logic       ph1_neg,
  output logic [1:0] ph1_decay,
  output logic [7:0] ph2_mag,
  output logic       ph2_neg,
  output logic [1:0] ph2_decay
);
  logic             step_evt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nxt;
  logic [MAG_W-1:0] mag_w [2];
  logic             neg_w [2];
  logic [1:0]       dec_w [2];

  stp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .clr(uv_req), .step_evt(step_evt)
  );

  stp_index u_index (
    .clk(clk), .rst_n(rst_n), .clr(uv_req), .step_evt(step_evt), .dir_in(dir_in),
    .res_a(res_a), .res_b(res_b), .idx(idx), .idx_nxt(idx_nxt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_phase
    stp_phase #(.USE_SIN(g == 1)) u_phase (
      .clk(clk), .rst_n(rst_n), .clr(uv_req), .step_evt(step_evt), .idx(idx),
      .idx_nxt(idx_nxt), .pfd_sel(pfd_sel), .mag(mag_w[g]), .neg(neg_w[g]),
      .decay(dec_w[g])
    );
  end

  assign ph1_mag   = mag_w[0];
  assign ph1_neg   = neg_w[0];
  assign ph1_decay = dec_w[0];
  assign ph2_mag   = mag_w[1];
  assign ph2_neg   = neg_w[1];
  assign ph2_decay = dec_w[1];

  assert_quadrature_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph1_mag == '0) |-> (ph2_mag == FULL_MAG));
  assert_quadrature_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_mag == '0) |-> (ph1_mag == FULL_MAG));
endmodule

// File: tb/tb_stp_translator.sv
module tb_stp_translator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_in = 1'b0;
  logic       dir_in = 1'b1;
  logic       res_a = 1'b0;
  logic       res_b = 1'b0;
  logic [1:0] pfd_sel = 2'b01;
  logic       uv_req = 1'b0;
  logic [7:0] ph1_mag, ph2_mag;
  logic       ph1_neg, ph2_neg;
  logic [1:0] ph1_decay, ph2_decay;

  int errors = 0;
  int checks = 0;
  int m_idx = 4;
  int m_dec [2] = '{1, 1};

  always #4 clk = ~clk;

  stp_translator dut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in), .res_a(res_a),
    .res_b(res_b), .pfd_sel(pfd_sel), .uv_req(uv_req), .ph1_mag(ph1_mag),
    .ph1_neg(ph1_neg), .ph1_decay(ph1_decay), .ph2_mag(ph2_mag), .ph2_neg(ph2_neg),
    .ph2_decay(ph2_decay)
  );

  function automatic real wave(int i, bit s);
    real a;
    a = i * 11.25 * 3.14159265358979 / 180.0;
    return s ? $sin(a) : $cos(a);
  endfunction

  function automatic int exp_mag(int i, bit s);
    real v;
    v = wave(i, s);
    if (v < 0.0) v = -v;
    return $rtoi(v * 255.0 + 0.5);
  endfunction

  function automatic int exp_neg(int i, bit s);
    return (wave(i, s) < -1.0e-6) ? 1 : 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (model index %0d)", req, what, act, exp, m_idx);
    end
  endtask

  task automatic check_all(string req);
    check(req, "ph1_mag", int'(ph1_mag), exp_mag(m_idx, 0));
    check(req, "ph1_neg", int'(ph1_neg), exp_neg(m_idx, 0));
    check(req, "ph1_decay", int'(ph1_decay), m_dec[0]);
    check(req, "ph2_mag", int'(ph2_mag), exp_mag(m_idx, 1));
    check(req, "ph2_neg", int'(ph2_neg), exp_neg(m_idx, 1));
    check(req, "ph2_decay", int'(ph2_decay), m_dec[1]);
  endtask

  function automatic int fall_code(logic [1:0] p);
    if (p == 2'b00) return 0;
    if (p == 2'b10) return 2;
    return 1;
  endfunction

  task automatic model_step(bit d, bit ms1, bit ms2, logic [1:0] p);
    int inc, oldm, newm, nidx;
    inc = 8 >> ((ms2 ? 2 : 0) + (ms1 ? 1 : 0));
    nidx = d ? (m_idx + inc) % 32 : (m_idx + 32 - inc) % 32;
    for (int ph = 0; ph < 2; ph++) begin
      oldm = exp_mag(m_idx, ph[0]);
      newm = exp_mag(nidx, ph[0]);
      m_dec[ph] = (newm < oldm) ? fall_code(p) : 0;
    end
    m_idx = nidx;
  endtask

  task automatic model_home();
    m_idx = 4;
    m_dec[0] = 1;
    m_dec[1] = 1;
  endtask

  task automatic do_step(bit d, bit ms1, bit ms2, logic [1:0] p, string req);
    @(negedge clk);
    dir_in = d; res_a = ms1; res_b = ms2; pfd_sel = p; step_in = 1'b1;
    model_step(d, ms1, ms2, p);
    @(negedge clk);
    check_all(req);
    step_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    model_home();
    check_all("R1");
  endtask

  task automatic t_eighth_forward();
    for (int k = 0; k < 32; k++) do_step(1'b1, 1'b1, 1'b1, 2'b01, "R2");
  endtask

  task automatic t_quarter_reverse();
    for (int k = 0; k < 16; k++) do_step(1'b0, 1'b0, 1'b1, 2'b10, "R3");
  endtask

  task automatic t_half_mixed_unused();
    for (int k = 0; k < 8; k++) do_step(1'b1, 1'b1, 1'b0, 2'b11, "R8");
  endtask

  task automatic t_full_slow();
    for (int k = 0; k < 5; k++) do_step(1'b0, 1'b0, 1'b0, 2'b00, "R3");
  endtask

  task automatic t_held_step();
    @(negedge clk);
    dir_in = 1'b1; res_a = 1'b1; res_b = 1'b1; pfd_sel = 2'b10; step_in = 1'b1;
    model_step(1'b1, 1'b1, 1'b1, 2'b10);
    repeat (6) @(negedge clk);
    check_all("R4");
    step_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_res_latched();
    @(negedge clk);
    res_a = 1'b0; res_b = 1'b0; dir_in = 1'b0; pfd_sel = 2'b00;
    repeat (3) @(negedge clk);
    check_all("R5");
    do_step(1'b1, 1'b0, 1'b1, 2'b01, "R5");
  endtask

  task automatic t_no_realign();
    // from index 4 go to 5 in eighth steps, then full step to 13
    do_step(1'b1, 1'b1, 1'b1, 2'b01, "R9");
    do_step(1'b1, 1'b0, 1'b0, 2'b01, "R9");
    check("R9", "ph1_mag_at_13", int'(ph1_mag), 212);
    check("R9", "ph2_mag_at_13", int'(ph2_mag), 142);
  endtask

  task automatic t_reset_hold();
    do_step(1'b1, 1'b1, 1'b0, 2'b10, "R6");
    @(negedge clk);
    rst_n = 1'b0;
    model_home();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); step_in = 1'b1;
      @(negedge clk); step_in = 1'b0;
    end
    check_all("R6");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R6");
  endtask

  task automatic t_uv_request();
    do_step(1'b0, 1'b1, 1'b1, 2'b10, "R7");
    do_step(1'b0, 1'b1, 1'b1, 2'b10, "R7");
    @(negedge clk);
    uv_req = 1'b1;
    model_home();
    @(negedge clk);
    check_all("R7");
    step_in = 1'b1;
    @(negedge clk);
    check_all("R7");
    step_in = 1'b0;
    uv_req = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R7");
    do_step(1'b1, 1'b0, 1'b1, 2'b00, "R7");
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_eighth_forward();
    t_quarter_reverse();
    t_half_mixed_unused();
    t_full_slow();
    t_held_step();
    t_res_latched();
    t_reset_hold();
    t_no_realign();
    t_uv_request();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule